// File: doc/BRIEF.md
# Cross-Lane Data Mover

This block moves 32-bit values between the lanes of a 64-lane wavefront in a single clocked step. The lanes form four rows of sixteen, and each row is split into four banks of four lanes. A control code and a selector word choose a pattern: a permute inside groups of four, a mirror across a row or half-row, a shift or rotate inside a row, a broadcast from the end of one row into later rows, a one-lane shift or rotate across the whole wave, or a free choice of source inside each group of eight. For every destination lane the block finds a source lane and fetches that lane's word.

Policy controls then decide what each lane finally receives. Row and bank enables keep a lane's old value when its row or bank is switched off. A source with no lane behind it, because it was shifted out or has no broadcast source, counts as invalid. A source whose execute bit is clear counts as inactive. A bound flag and a fetch-inactive flag choose between zero, the old destination value and the source word. A half-wave flag limits the operation to the two lower rows. The caller supplies the old destination words on a separate bus. The result is registered and shown one cycle after the request.

Top module: `xlane_mover`

## Requirements
- R1: `out_valid` is high in the cycle after a cycle with `in_valid` high and low otherwise. `out_data` loads only on such a request and holds its value between requests. Reset clears both to zero.
- R2: Mode code 0 (quad permute): destination lane d reads lane 4*(d/4) + s, where s is `mode_sel[2*(d%4)+1 : 2*(d%4)]`.
- R3: Mode 1 (row mirror): lane d reads 16*(d/16) + 15 - d%16. Mode 2 (half-row mirror): lane d reads 8*(d/8) + 7 - d%8.
- R4: Modes 3, 4 and 5 take the amount n = `mode_sel[3:0]` and stay inside a row. Mode 3 shifts left: lane d reads d+n, and is invalid when d%16 + n > 15. Mode 4 shifts right: lane d reads d-n, and is invalid when d%16 < n. Mode 5 rotates right: lane d reads 16*(d/16) + (d%16 - n) mod 16.
- R5: Mode 6: each row r ≥ 1 reads lane 16r-1, and row 0 has an invalid source. Mode 7: rows 2 and 3 read lane 31, and rows 0 and 1 have an invalid source.
- R6: Over a wave of W lanes (W = 64, or 32 in half-wave mode), mode 8 has lane d read d+1 (invalid at d = W-1) and mode 9 has lane d read (d+1) mod W. Mode 10 has lane d read d-1 (invalid at d = 0) and mode 11 has lane d read (d-1) mod W.
- R7: Mode 12 (group-of-eight select): lane d reads 8*(d/8) + `mode_sel[3*(d%8)+2 : 3*(d%8)]`.
- R8: In every mode except 12, lane d is written only when `row_en[d/16]` and `bank_en[(d%16)/4]` are both 1. Otherwise it receives `old_data` lane d. The enables have no effect in mode 12.
- R9: When a lane's source is invalid (outside its row or wave, without a broadcast source, or in rows 2 and 3 during half-wave mode), the lane receives zero if `bound_zero` is 1 and its `old_data` word if `bound_zero` is 0.
- R10: In modes 0 to 11 and 13 to 15, a valid source whose `exec_mask` bit is 0 still supplies its word when `fetch_inactive` is 1. When `fetch_inactive` is 0, such a source is treated as in R9.
- R11: In mode 12, a source whose `exec_mask` bit is 0 yields zero unless `fetch_inactive` is 1, and `bound_zero` has no effect.
- R12: With `half_wave` set, lanes 32 to 63 always receive their `old_data` word.
- R13: Mode codes 13, 14 and 15 make each lane read itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| mode_code | input | 4 | Data-movement pattern |
| mode_sel | input | 24 | Lane selectors or shift amount |
| row_en | input | 4 | Per-row write enable |
| bank_en | input | 4 | Per-bank write enable |
| bound_zero | input | 1 | Invalid sources read zero |
| fetch_inactive | input | 1 | Inactive sources still supply data |
| half_wave | input | 1 | Use only rows 0 and 1 |
| exec_mask | input | 64 | Active bit per source lane |
| src_data | input | 2048 | Source words, lane i at bits 32i+31:32i |
| old_data | input | 2048 | Current destination words, same packing |
| out_valid | output | 1 | Result valid |
| out_data | output | 2048 | Result words, same packing |

## Verification
A wrong source index or a wrong validity flag for one lane shows up as a wrong word in that lane only, in the first output cycle after the request. No state carries over between requests, so a fault never hides until later. Each mode is therefore swept with several selectors, both wave sizes, both policy flags, sparse execute masks and rotating enable masks, and every lane of every result is compared. A fault in the output register shows up as a word that changes during an idle cycle.

// File: rtl/xl_pkg.sv
package xl_pkg;
  localparam int SEL_W = 24;

  typedef enum logic [3:0] {
    XM_QUAD = 4'd0,
    XM_RMIR = 4'd1,
    XM_HMIR = 4'd2,
    XM_RSHL = 4'd3,
    XM_RSHR = 4'd4,
    XM_RROR = 4'd5,
    XM_BCRW = 4'd6,
    XM_BCPR = 4'd7,
    XM_WSHL = 4'd8,
    XM_WROL = 4'd9,
    XM_WSHR = 4'd10,
    XM_WROR = 4'd11,
    XM_SEL8 = 4'd12
  } xl_mode_e;
endpackage

// File: rtl/xl_src_map.sv
module xl_src_map
  import xl_pkg::*;
#(
  parameter int LANES     = 64,
  parameter int ROW_LANES = 16,
  parameter int LANE      = 0
) (
  input  logic [3:0]           mode_code,
  input  logic [SEL_W-1:0]     mode_sel,
  input  logic                 half_wave,
  output logic [$clog2(LANES)-1:0] src_idx,
  output logic                 src_ok
);
  localparam int LIDX  = $clog2(LANES);
  localparam int AMT_W = $clog2(ROW_LANES);
  localparam int ROW   = LANE / ROW_LANES;
  localparam int POS   = LANE % ROW_LANES;
  localparam int RBASE = ROW * ROW_LANES;
  localparam int QBASE = (LANE / 4) * 4;
  localparam int OBASE = (LANE / 8) * 8;
  localparam int QSLOT = LANE % 4;
  localparam int OSLOT = LANE % 8;

  int   cand;
  int   amt;
  int   wlen;
  logic ok;

  always_comb begin
    amt  = int'(mode_sel[AMT_W-1:0]);
    wlen = half_wave ? (LANES / 2) : LANES;
    cand = LANE;
    ok   = 1'b1;
    case (mode_code)
      XM_QUAD: cand = QBASE + int'(mode_sel[2*QSLOT +: 2]);
      XM_RMIR: cand = RBASE + (ROW_LANES - 1 - POS);
      XM_HMIR: cand = OBASE + (7 - OSLOT);
      XM_RSHL: begin
        ok   = (POS + amt) < ROW_LANES;
        cand = LANE + amt;
      end
      XM_RSHR: begin
        ok   = POS >= amt;
        cand = LANE - amt;
      end
      XM_RROR: cand = RBASE + ((POS + ROW_LANES - amt) % ROW_LANES);
      XM_BCRW: begin
        ok   = (ROW >= 1);
        cand = RBASE - 1;
      end
      XM_BCPR: begin
        ok   = (ROW >= 2);
        cand = 2 * ROW_LANES - 1;
      end
      XM_WSHL: begin
        cand = LANE + 1;
        ok   = cand < wlen;
      end
      XM_WROL: cand = (LANE + 1 >= wlen) ? 0 : LANE + 1;
      XM_WSHR: begin
        cand = LANE - 1;
        ok   = (LANE > 0);
      end
      XM_WROR: cand = (LANE == 0) ? wlen - 1 : LANE - 1;
      XM_SEL8: cand = OBASE + int'(mode_sel[3*OSLOT +: 3]);
      default: cand = LANE;
    endcase
    if (half_wave && (cand >= LANES / 2)) ok = 1'b0;
    if (cand < 0 || cand >= LANES) ok = 1'b0;
  end

  assign src_idx = cand[LIDX-1:0];
  assign src_ok  = ok;
endmodule

// File: rtl/xl_lane_pick.sv
module xl_lane_pick #(
  parameter int DW = 32
) (
  input  logic [DW-1:0] src_word,
  input  logic          src_active,
  input  logic          src_ok,
  input  logic [DW-1:0] old_word,
  input  logic          wr_en,
  input  logic          zero_inactive,
  input  logic          bound_zero,
  input  logic          fetch_inactive,
  output logic [DW-1:0] res_word
);
  logic take_src;

  always_comb begin
    take_src = src_ok && (src_active || fetch_inactive);
    if (!wr_en) begin
      res_word = old_word;
    end else if (take_src) begin
      res_word = src_word;
    end else if (zero_inactive || bound_zero) begin
      res_word = '0;
    end else begin
      res_word = old_word;
    end
  end
endmodule

// File: rtl/xlane_mover.sv
module xlane_mover
  import xl_pkg::*;
#(
  parameter int LANES     = 64,
  parameter int ROW_LANES = 16,
  parameter int BANK_LANES = 4,
  parameter int DW        = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [3:0]              mode_code,
  input  logic [SEL_W-1:0]        mode_sel,
  input  logic [LANES/ROW_LANES-1:0] row_en,
  input  logic [ROW_LANES/BANK_LANES-1:0] bank_en,
  input  logic                    bound_zero,
  input  logic                    fetch_inactive,
  input  logic                    half_wave,
  input  logic [LANES-1:0]        exec_mask,
  input  logic [LANES*DW-1:0]     src_data,
  input  logic [LANES*DW-1:0]     old_data,
  output logic                    out_valid,
  output logic [LANES*DW-1:0]     out_data
);
  localparam int LIDX  = $clog2(LANES);
  localparam int ROWS  = LANES / ROW_LANES;
  localparam int BANKS = ROW_LANES / BANK_LANES;

  logic                is_sel8;
  logic [LANES*DW-1:0] lane_res;
  logic [LANES*DW-1:0] data_nxt;
  logic                valid_nxt;

  assign is_sel8 = (mode_code == XM_SEL8);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam int  ROW    = g / ROW_LANES;
    localparam int  BANK   = (g % ROW_LANES) / BANK_LANES;
    localparam bit  IN_LOW = (g < LANES / 2);

    logic [LIDX-1:0] sidx;
    logic            sok;
    logic            wen;
    logic            live;

    xl_src_map #(
      .LANES(LANES), .ROW_LANES(ROW_LANES), .LANE(g)
    ) u_map (
      .mode_code(mode_code),
      .mode_sel (mode_sel),
      .half_wave(half_wave),
      .src_idx  (sidx),
      .src_ok   (sok)
    );

    assign live = !half_wave || IN_LOW;
    assign wen  = live && (is_sel8 || (row_en[ROW] && bank_en[BANK]));

    xl_lane_pick #(.DW(DW)) u_pick (
      .src_word      (src_data[sidx*DW +: DW]),
      .src_active    (exec_mask[sidx]),
      .src_ok        (sok),
      .old_word      (old_data[g*DW +: DW]),
      .wr_en         (wen),
      .zero_inactive (is_sel8),
      .bound_zero    (bound_zero),
      .fetch_inactive(fetch_inactive),
      .res_word      (lane_res[g*DW +: DW])
    );
  end

  always_comb begin
    valid_nxt = in_valid;
    data_nxt  = in_valid ? lane_res : out_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= valid_nxt;
      out_data  <= data_nxt;
    end
  end

  if (ROWS * ROW_LANES != LANES || BANKS * BANK_LANES != ROW_LANES) begin : g_bad_cfg
    initial $error("lane, row and bank sizes must divide evenly");
  end
endmodule

// File: rtl/xlane_mover_chk.sv
module xlane_mover_chk
  import xl_pkg::*;
#(
  parameter int LANES      = 64,
  parameter int ROW_LANES  = 16,
  parameter int BANK_LANES = 4,
  parameter int DW         = 32
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic [3:0]              mode_code,
  input logic [SEL_W-1:0]        mode_sel,
  input logic [LANES/ROW_LANES-1:0] row_en,
  input logic [ROW_LANES/BANK_LANES-1:0] bank_en,
  input logic                    bound_zero,
  input logic                    fetch_inactive,
  input logic                    half_wave,
  input logic [LANES-1:0]        exec_mask,
  input logic [LANES*DW-1:0]     src_data,
  input logic [LANES*DW-1:0]     old_data,
  input logic                    out_valid,
  input logic [LANES*DW-1:0]     out_data
);
  localparam int BANKS = ROW_LANES / BANK_LANES;

  p_valid_rise_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_valid_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  p_hold_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_data));

  p_mirror_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode_code == XM_RMIR && row_en[0] && bank_en[0]
     && exec_mask[ROW_LANES-1])
    |=> out_data[DW-1:0] == $past(src_data[(ROW_LANES-1)*DW +: DW]));

  p_mask_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode_code != XM_SEL8 && !row_en[0])
    |=> out_data[DW-1:0] == $past(old_data[DW-1:0]));

  p_bound_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode_code == XM_RSHL && mode_sel[3:0] != 4'd0 && bound_zero
     && row_en[0] && bank_en[BANKS-1])
    |=> out_data[(ROW_LANES-1)*DW +: DW] == '0);

  p_sel8_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode_code == XM_SEL8 && !fetch_inactive
     && !exec_mask[mode_sel[2:0]])
    |=> out_data[DW-1:0] == '0);

  p_half_keep_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && half_wave)
    |=> out_data[(LANES-1)*DW +: DW] == $past(old_data[(LANES-1)*DW +: DW]));
endmodule

bind xlane_mover xlane_mover_chk #(
  .LANES(LANES), .ROW_LANES(ROW_LANES), .BANK_LANES(BANK_LANES), .DW(DW)
) u_chk (.*);

// File: tb/test_xlane_mover.sv
module test_xlane_mover;
  localparam int L  = 64;
  localparam int DW = 32;

  logic          clk;
  logic          rst_n;
  logic          in_valid;
  logic [3:0]    mode_code;
  logic [23:0]   mode_sel;
  logic [3:0]    row_en;
  logic [3:0]    bank_en;
  logic          bound_zero;
  logic          fetch_inactive;
  logic          half_wave;
  logic [L-1:0]  exec_mask;
  logic [L*DW-1:0] src_data;
  logic [L*DW-1:0] old_data;
  logic          out_valid;
  logic [L*DW-1:0] out_data;

  logic [31:0] srcw [L];
  logic [31:0] oldw [L];
  logic [31:0] expw [L];

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  xlane_mover i_xlane_mover (
    .clk, .rst_n, .in_valid, .mode_code, .mode_sel, .row_en, .bank_en,
    .bound_zero, .fetch_inactive, .half_wave, .exec_mask,
    .src_data, .old_data, .out_valid, .out_data
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic string mode_tag(input int m);
    case (m)
      0:           return "R2";
      1, 2:        return "R3";
      3, 4, 5:     return "R4";
      6, 7:        return "R5";
      8, 9, 10, 11: return "R6";
      12:          return "R7";
      default:     return "R13";
    endcase
  endfunction

  // Reference per lane, written from the requirement text.
  function automatic void model(input int d, output logic [31:0] v, output string tag);
    int m  = int'(mode_code);
    int w  = half_wave ? 32 : 64;
    int r  = d / 16;
    int p  = d % 16;
    int n  = int'(mode_sel[3:0]);
    int s;
    bit ok = 1;
    tag = mode_tag(m);
    if (half_wave && d >= 32) begin v = oldw[d]; tag = "R12"; return; end
    if (m != 12 && !(row_en[r] && bank_en[p/4])) begin v = oldw[d]; tag = "R8"; return; end
    case (m)
      0:  s = d - d % 4 + int'((mode_sel >> (2 * (d % 4))) & 24'd3);
      1:  s = 16 * r + 15 - p;
      2:  s = d - d % 8 + 7 - d % 8;
      3:  begin s = d + n; ok = (p + n < 16); end
      4:  begin s = d - n; ok = (p >= n); end
      5:  s = 16 * r + (p + 16 - n) % 16;
      6:  begin s = 16 * r - 1; ok = (r >= 1); end
      7:  begin s = 31; ok = (r >= 2); end
      8:  begin s = d + 1; ok = (s < w); end
      9:  s = (d + 1) % w;
      10: begin s = d - 1; ok = (d > 0); end
      11: s = (d + w - 1) % w;
      12: s = d - d % 8 + int'((mode_sel >> (3 * (d % 8))) & 24'd7);
      default: s = d;
    endcase
    if (ok && half_wave && s >= 32) ok = 0;
    if (!ok) begin
      tag = "R9";
      v = bound_zero ? 32'h0 : oldw[d];
      return;
    end
    if (!exec_mask[s] && !fetch_inactive) begin
      tag = (m == 12) ? "R11" : "R10";
      v = (m == 12 || bound_zero) ? 32'h0 : oldw[d];
      return;
    end
    v = srcw[s];
  endfunction

  task automatic pack_buses();
    for (int i = 0; i < L; i++) begin
      src_data[i*DW +: DW] = srcw[i];
      old_data[i*DW +: DW] = oldw[i];
    end
  endtask

  task automatic run_one(input int run, input int m, input logic [23:0] sel,
                         input bit hw, input bit bz, input bit fi,
                         input logic [63:0] ex);
    logic [3:0] rpat [4] = '{4'hF, 4'h5, 4'hA, 4'hF};
    logic [3:0] bpat [3] = '{4'hF, 4'h3, 4'hC};
    string tag;
    for (int i = 0; i < L; i++) begin
      srcw[i] = {run[15:0], 8'h5A, 8'(i)};
      oldw[i] = {8'hD0, run[11:0], 4'h0, 8'(i)} | 32'h1;
    end
    mode_code      = 4'(m);
    mode_sel       = sel;
    half_wave      = hw;
    bound_zero     = bz;
    fetch_inactive = fi;
    exec_mask      = ex;
    row_en         = rpat[run % 4];
    bank_en        = bpat[(run / 4) % 3];
    pack_buses();
    for (int i = 0; i < L; i++) begin
      model(i, expw[i], tag);
    end
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid == 1'b1, "R1", "valid after request", 32'(out_valid), 32'h1);
    for (int i = 0; i < L; i++) begin
      logic [31:0] e;
      model(i, e, tag);
      check(out_data[i*DW +: DW] == e, tag,
            $sformatf("mode %0d lane %0d sel %h half %0d bz %0d fi %0d", m, i, sel, hw, bz, fi),
            out_data[i*DW +: DW], e);
    end
    // Change inputs while idle: the result must hold (R1).
    for (int i = 0; i < L; i++) srcw[i] = ~srcw[i];
    pack_buses();
    exec_mask = ~ex;
    @(negedge clk);
    check(out_valid == 1'b0, "R1", "valid idle", 32'(out_valid), 32'h0);
    for (int i = 0; i < L; i += 9) begin
      check(out_data[i*DW +: DW] == expw[i], "R1", $sformatf("hold lane %0d", i),
            out_data[i*DW +: DW], expw[i]);
    end
  endtask

  initial begin
    logic [23:0] sels [5] = '{24'h00001B, 24'h000001, 24'h00000F, 24'h000008, 24'h5A3C96};
    logic [63:0] exs  [2] = '{64'hFFFF_FFFF_FFFF_FFFF, 64'h96F0_3C5A_A5C3_0F69};
    int run = 0;
    rst_n = 1'b0;
    in_valid = 1'b0;
    mode_code = '0; mode_sel = '0; row_en = '1; bank_en = '1;
    bound_zero = 1'b0; fetch_inactive = 1'b0; half_wave = 1'b0;
    exec_mask = '1; src_data = '1; old_data = '1;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1", "reset valid", 32'(out_valid), 32'h0);
    check(out_data == '0, "R1", "reset data", out_data[31:0], 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int m = 0; m < 16; m++)
      for (int si = 0; si < 5; si++)
        for (int h = 0; h < 2; h++)
          for (int b = 0; b < 2; b++)
            for (int f = 0; f < 2; f++)
              for (int e = 0; e < 2; e++) begin
                run_one(run, m, sels[si], h[0], b[0], f[0], exs[e]);
                run++;
              end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog run did not finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule